// File: doc/BRIEF.md
# Serial Port Modem Status and Divisor Register Bank

This block is the part of a 16550-style serial port register file that sits between the host CPU and the modem control lines. It sits on an 8-bit data, 3-bit address CPU bus. It samples four modem lines, clear-to-send, data-set-ready, ring and carrier-detect, through a two-flop synchronizer and shows their current levels. It keeps a sticky change flag for each line, and these flags clear when the status register is read. While any flag is set, a modem status interrupt is raised.

The bank also holds a general-purpose scratch byte and the two divisor bytes. It turns the divisor into a baud tick derived from a 115200 Hz reference strobe. The divisor latch access bit lives in the line control register, which is outside this block, so it arrives as an input pin. The CPU bus is a plain register interface and has no back-pressure. A write is taken in the cycle where `wr_en` is high. Read data is combinational from `addr` in every cycle. A cycle with `rd_en` high counts as one read access.

Top module: `serial_modem_regs`

## Requirements
- R1: The status register (address 6) shows the synchronized line levels in its upper nibble: bit 7 carrier-detect, bit 6 ring, bit 5 data-set-ready, bit 4 clear-to-send. A level change on a pin becomes visible no later than the third rising clock edge after it.
- R2: After reset, the lower nibble of the status register is 0, the scratch register and both divisor bytes are 00h, `divisor` is 0, `msi_irq` is 0 and no `baud_tick` is produced.
- R3: Bit 0 (clear-to-send change), bit 1 (data-set-ready change) and bit 3 (carrier-detect change) set when the matching line changes level in either direction. Each stays set until the status register is read, even if the line returns to its old level.
- R4: Bit 2 (ring trailing edge) sets only when the ring line goes from low to high. A high-to-low change of the ring line leaves it unchanged.
- R5: A read of address 6 returns the flags as they were before the read. It clears bits 0 to 3 at the end of that cycle.
- R6: A line change that is detected in the same cycle as a status register read leaves its flag set after the read.
- R7: `msi_irq` is high exactly while any of status bits 0 to 3 is 1.
- R8: Address 7 is a read/write scratch byte. Writing it, or writing addresses 2 to 6, changes neither the status register nor `divisor`.
- R9: While `dl_access` is 1, address 0 reads and writes the divisor low byte and address 1 reads and writes the divisor high byte, and `divisor` = {high, low}. While `dl_access` is 0, writes to addresses 0 and 1 are ignored and those addresses read 00h.
- R10: With divisor D ≥ 1, `baud_tick` pulses for one clock once every D reference strobes, which gives a rate of 115200/D (D = 12 gives 9600). While D = 0, no tick is produced.
- R11: A new divisor takes effect at the next counter reload. The interval that is running when the divisor is written still uses the old value, and every interval after it uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| rd_en | input | 1 | Read strobe, one read access per high cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| dl_access | input | 1 | Divisor latch access bit from the line control register |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| ri_in | input | 1 | Ring line, asynchronous |
| dcd_in | input | 1 | Carrier-detect line, asynchronous |
| ref_tick | input | 1 | One-clock strobe at 115200 Hz |
| msi_irq | output | 1 | Modem status interrupt |
| divisor | output | 16 | Current divisor |
| baud_tick | output | 1 | One-clock baud rate strobe |

## Verification
The assertions assume three things about the inputs:
- `rd_en` marks one read access for each cycle it is high.
- `ref_tick` is a single-cycle strobe.
- The modem lines may move at any clock phase, because every property is written against the synchronized levels.

The stimulus changes every input on the falling clock edge. It holds `rd_en` high for exactly one cycle per access and pulses `ref_tick` for one clock out of every three. It also places one line change exactly in the cycle of a status read, so that the rule that a change in the read cycle is not lost gets exercised.

// File: rtl/smr_pkg.sv
package smr_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned LINES   = 4;
  localparam int unsigned CNT_W   = 16;

  // line index order inside the 4-bit level/flag vectors
  localparam int unsigned IX_CTS = 0;
  localparam int unsigned IX_DSR = 1;
  localparam int unsigned IX_RI  = 2;
  localparam int unsigned IX_DCD = 3;

  localparam logic [ADDR_W-1:0] A_DIV_LO  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV_HI  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd6;
  localparam logic [ADDR_W-1:0] A_SCRATCH = 3'd7;
endpackage

// File: rtl/smr_sync.sv
module smr_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/smr_delta.sv
module smr_delta #(
  parameter int unsigned N      = 4,
  parameter int unsigned RI_IDX = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines_s,
  input  logic         rd_stat,
  output logic [N-1:0] lvl,
  output logic [N-1:0] dlt
);
  logic [N-1:0] lvl_q, dlt_q, chg, dlt_d;

  for (genvar i = 0; i < int'(N); i++) begin : g_edge
    if (i == int'(RI_IDX)) begin : g_rise
      assign chg[i] = lines_s[i] & ~lvl_q[i];
    end else begin : g_any
      assign chg[i] = lines_s[i] ^ lvl_q[i];
    end
  end

  // a new change wins over the clear from a read in the same cycle
  assign dlt_d = (rd_stat ? '0 : dlt_q) | chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      dlt_q <= '0;
    end else begin
      lvl_q <= lines_s;
      dlt_q <= dlt_d;
    end
  end

  assign lvl = lvl_q;
  assign dlt = dlt_q;

  AST_TERI_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlt_q[RI_IDX]) |-> (lvl_q[RI_IDX] && !$past(lvl_q[RI_IDX]))); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> ((dlt_q & $past(dlt_q)) == $past(dlt_q))); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && chg == '0) |=> (dlt_q == '0)); // R5
  AST_NO_LOST_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && chg != '0) |=> ((dlt_q & $past(chg)) == $past(chg))); // R6
endmodule

// File: rtl/smr_baud.sv
module smr_baud #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic [CNT_W-1:0] div,
  output logic             baud_tick
);
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (ref_tick) begin
        if (div == '0) begin
          cnt_q <= '0;
        end else if (cnt_q == '0) begin
          cnt_q <= div;
        end else if (cnt_q == CNT_W'(1)) begin
          cnt_q  <= div;
          tick_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign baud_tick = tick_q;

  AST_TICK_FROM_REF: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> $past(ref_tick)); // R10
  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && div == '0) |=> !baud_tick); // R10
  AST_RELOAD_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> (cnt_q == $past(div))); // R11
endmodule

// File: rtl/serial_modem_regs.sv
module serial_modem_regs
  import smr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              dl_access,
  input  logic              cts_in,
  input  logic              dsr_in,
  input  logic              ri_in,
  input  logic              dcd_in,
  input  logic              ref_tick,
  output logic              msi_irq,
  output logic [CNT_W-1:0]  divisor,
  output logic              baud_tick
);
  localparam int unsigned HALF = CNT_W / 2;

  logic [LINES-1:0]  raw_lines, sync_lines, lvl, dlt;
  logic [HALF-1:0]   div_lo_q, div_hi_q;
  logic [DATA_W-1:0] scratch_q, status;
  logic              rd_stat;

  assign raw_lines[IX_CTS] = cts_in;
  assign raw_lines[IX_DSR] = dsr_in;
  assign raw_lines[IX_RI]  = ri_in;
  assign raw_lines[IX_DCD] = dcd_in;

  smr_sync #(.W(LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_lines), .dout(sync_lines)
  );

  assign rd_stat = rd_en && (addr == A_STATUS);

  smr_delta #(.N(LINES), .RI_IDX(IX_RI)) u_delta (
    .clk(clk), .rst_n(rst_n), .lines_s(sync_lines), .rd_stat(rd_stat),
    .lvl(lvl), .dlt(dlt)
  );

  assign status  = {lvl, dlt};
  assign msi_irq = |dlt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo_q  <= '0;
      div_hi_q  <= '0;
      scratch_q <= '0;
    end else if (wr_en) begin
      if (addr == A_SCRATCH) scratch_q <= wdata;
      if (dl_access && addr == A_DIV_LO) div_lo_q <= wdata;
      if (dl_access && addr == A_DIV_HI) div_hi_q <= wdata;
    end
  end

  assign divisor = {div_hi_q, div_lo_q};

  always_comb begin
    rdata = '0;
    case (addr)
      A_DIV_LO:  if (dl_access) rdata = div_lo_q;
      A_DIV_HI:  if (dl_access) rdata = div_hi_q;
      A_STATUS:  rdata = status;
      A_SCRATCH: rdata = scratch_q;
      default:   rdata = '0;
    endcase
  end

  smr_baud #(.CNT_W(CNT_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .div(divisor),
    .baud_tick(baud_tick)
  );

  AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_STATUS) |-> (msi_irq == (rdata[3:0] != 4'h0))); // R7
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && dl_access && addr[2:1] == 2'b00) |=> $stable(divisor)); // R9
  AST_STATUS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && sync_lines == lvl) |=> $stable(status)); // R8
endmodule

// File: tb/sim_serial_modem_regs.sv
module sim_serial_modem_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, dl_access = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        cts_in = 0, dsr_in = 0, ri_in = 0, dcd_in = 0;
  logic        ref_tick = 1'b0;
  logic        msi_irq, baud_tick;
  logic [15:0] divisor;

  int checks = 0;
  int errors = 0;
  int refcnt = 0;
  int tickcnt = 0;

  serial_modem_regs u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .dl_access(dl_access),
    .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in), .dcd_in(dcd_in),
    .ref_tick(ref_tick), .msi_irq(msi_irq), .divisor(divisor),
    .baud_tick(baud_tick)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (ref_tick) refcnt <= refcnt + 1;
    if (baud_tick) tickcnt <= tickcnt + 1;
  end

  initial begin
    forever begin
      repeat (2) @(negedge clk);
      ref_tick = 1'b1;
      @(negedge clk);
      ref_tick = 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #4 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_lines(input logic [3:0] v);
    @(negedge clk);
    {dcd_in, ri_in, dsr_in, cts_in} = v;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [3:0] flags(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] f;
    f[0] = a[0] ^ b[0];
    f[1] = a[1] ^ b[1];
    f[2] = ~a[2] & b[2];
    f[3] = a[3] ^ b[3];
    return f;
  endfunction

  task automatic wait_tick();
    @(negedge clk);
    while (!baud_tick) @(negedge clk);
  endtask

  task automatic measure(output int spacing);
    int r0;
    wait_tick();
    r0 = refcnt;
    wait_tick();
    spacing = refcnt - r0;
  endtask

  initial begin
    logic [7:0] d;
    int sp, r0, t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    t0 = tickcnt;
    rd(3'd6, d);   check("R2 status low nibble", d[3:0], 0);
    rd(3'd7, d);   check("R2 scratch", d, 0);
    check("R2 divisor", divisor, 0);
    check("R2 irq", msi_irq, 0);
    dl_access = 1'b1;
    rd(3'd0, d);   check("R2 div lo", d, 0);
    rd(3'd1, d);   check("R2 div hi", d, 0);
    repeat (60) @(negedge clk);
    check("R2 no tick at reset", tickcnt - t0, 0);

    // R1 R3 R4 R5 R7: all from/to pairs of line levels
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        set_lines(4'(a));
        rd(3'd6, d);
        set_lines(4'(b));
        check("R7 irq before read", msi_irq, int'(|flags(4'(a), 4'(b))));
        rd(3'd6, d);
        check("R1 R3 R4 status", d, {4'(b), flags(4'(a), 4'(b))});
        rd(3'd6, d);
        check("R5 cleared by read", d, {4'(b), 4'h0});
        check("R7 irq after clear", msi_irq, 0);
      end
    end

    // R3 sticky through a return to the old level
    set_lines(4'h0); rd(3'd6, d);
    set_lines(4'h1); set_lines(4'h0);
    rd(3'd6, d); check("R3 sticky cts flag", d, 8'h01);
    set_lines(4'h8); set_lines(4'h0);
    rd(3'd6, d); check("R3 sticky dcd flag", d, 8'h08);
    // R4 ring pulse rises then falls: trailing-edge flag stays set
    set_lines(4'h4); set_lines(4'h0);
    rd(3'd6, d); check("R4 ring pulse", d, 8'h04);

    // R6 change lands in the cycle of the status read
    @(negedge clk);
    dsr_in = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    addr = 3'd6; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    rd(3'd6, d); check("R6 same-cycle change kept", d, 8'h22);
    rd(3'd6, d); check("R6 then cleared", d, 8'h20);
    set_lines(4'h0); rd(3'd6, d);

    // R8 scratch and writes to other addresses
    for (int v = 0; v < 256; v += 17) begin
      wr(3'd7, 8'(v));
      rd(3'd7, d); check("R8 scratch readback", d, v);
    end
    for (int a = 2; a < 7; a++) wr(3'(a), 8'hFF);
    rd(3'd6, d); check("R8 status untouched", d, 0);
    check("R8 divisor untouched", divisor, 0);
    rd(3'd3, d); check("R8 unused addr reads 0", d, 0);

    // R9 divisor latch access
    dl_access = 1'b1;
    wr(3'd0, 8'hA5); wr(3'd1, 8'h3C);
    check("R9 divisor value", divisor, 16'h3CA5);
    rd(3'd0, d); check("R9 lo readback", d, 8'hA5);
    rd(3'd1, d); check("R9 hi readback", d, 8'h3C);
    dl_access = 1'b0;
    wr(3'd0, 8'h11); wr(3'd1, 8'h22);
    check("R9 write ignored without access", divisor, 16'h3CA5);
    rd(3'd0, d); check("R9 lo reads 0 without access", d, 0);
    rd(3'd1, d); check("R9 hi reads 0 without access", d, 0);
    dl_access = 1'b1;
    wr(3'd1, 8'h00); wr(3'd0, 8'h00);

    // R10 zero divisor is silent, then sweep small divisors
    t0 = tickcnt;
    repeat (100) @(negedge clk);
    check("R10 no tick at zero divisor", tickcnt - t0, 0);
    for (int dv = 1; dv <= 12; dv++) begin
      wr(3'd0, 8'(dv));
      measure(sp);
      check("R10 tick spacing", sp, dv);
    end
    check("R10 rate at divisor 12", 115200 / sp, 9600);
    wr(3'd1, 8'h09); wr(3'd0, 8'h00);
    measure(sp);
    check("R10 divisor 2304 spacing", sp, 2304);
    check("R10 rate at divisor 2304", 115200 / sp, 50);

    // R11 new divisor used from the next reload
    wr(3'd1, 8'h00); wr(3'd0, 8'd5);
    wait_tick();
    wait_tick();
    r0 = refcnt;
    wr(3'd0, 8'd3);
    wait_tick();
    check("R11 running interval keeps old divisor", refcnt - r0, 5);
    r0 = refcnt;
    wait_tick();
    check("R11 next interval uses new divisor", refcnt - r0, 3);

    wr(3'd0, 8'd0);
    repeat (10) @(negedge clk);
    t0 = tickcnt;
    repeat (60) @(negedge clk);
    check("R10 silent after divisor cleared", tickcnt - t0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule